// File: doc/BRIEF.md
# Active Priority Level Tracker

This block records which interrupt priority levels are currently being serviced, separately for interrupt group 0 and group 1. Each group owns a bitmap with one bit per implemented priority level. When an interrupt is acknowledged, the caller pulses the activate strobe with the interrupt's group and 8-bit priority, and the matching level bit is set. When the handler signals a priority drop for a group, the most urgent level still marked in that group's bitmap is released.

The block continuously reports the running priority, which is the most urgent level set in either bitmap. It also reports which group owns that level. The running priority is found by locating the lowest set bit in each bitmap and comparing the two positions. No stack of nested priorities is kept. A build-time option selects a reduced mode with 32 levels. In that mode only the top five bits of each priority are used.

Top module: `apr_tracker`

## Requirements
- R1: With `VIRTUAL=0`, an activate of priority `p` marks level `L = p >> (8-PRIO_BITS)`. Once `L` is the winning level, `run_prio` equals `L << (8-PRIO_BITS)`, so the low `8-PRIO_BITS` bits of `p` are dropped. Level `L` sits in storage word `L/32` at bit `L%32`. `PRIO_BITS` ranges from 5 to 7.
- R2: With `VIRTUAL=1`, the priority is masked to `p & 8'hF8`, giving 32 levels whatever `PRIO_BITS` is. `run_prio` then reports `p & 8'hF8`.
- R3: Group 0 (`group=0`) and group 1 (`group=1`) keep independent bitmaps. Activating or dropping in one group never changes the levels marked in the other.
- R4: `run_prio` comes from the lowest-numbered level set in either group. `run_group` names the owning group. When both groups hold the same lowest level, group 0 wins.
- R5: When no level is set in either group, `run_prio` is `8'hFF` and `run_group` is 0.
- R6: A drop for a group clears only the lowest-numbered set level of that group's bitmap.
- R7: A drop when nothing is active in the requesting group, including when `run_prio` is `8'hFF`, has no effect.
- R8: When activate and drop arrive in the same cycle, the activate is applied first. The drop then clears the lowest set level of its group, which includes the level just activated.
- R9: Outputs reflect a strobe from the clock edge that samples it. With no strobe, `run_prio` and `run_group` hold their values.
- R10: After reset, both bitmaps are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_valid | input | 1 | Activate strobe |
| act_group | input | 1 | Group of the activated interrupt |
| act_prio | input | 8 | Priority of the activated interrupt |
| drop_valid | input | 1 | Priority drop strobe |
| drop_group | input | 1 | Group requesting the drop |
| run_prio | output | 8 | Current running priority, 8'hFF when idle |
| run_group | output | 1 | Group owning the running priority |

## Verification
Every priority value in both groups is swept through activate and drop on two configurations at once. One configuration has 64 levels spread over two storage words; the other uses the reduced 32-level mode. A wrong shift or a bad word split shows up as a wrong reported level. A design that clears the first word only would leave stale levels in the upper word.

Directed sequences cover three corners. Equal levels in both groups catch a tie rule that favours group 1. A drop on an empty or foreign bitmap catches a wrap-around clear of every bit. A same-cycle activate and drop catches a design that orders the two the wrong way and leaves the new level standing. A long pseudo-random run against an arithmetic model then checks clearing order, which would expose a design that releases the highest set bit or a bit in the wrong group.

// File: rtl/apr_pkg.sv
package apr_pkg;

    typedef enum logic {
        GRP_0 = 1'b0,
        GRP_1 = 1'b1
    } grp_e;

    // Number of priority bits that select a level; the reduced mode keeps five.
    function automatic int eff_bits(input int prio_bits, input bit virt);
        return virt ? 5 : prio_bits;
    endfunction

endpackage

// File: rtl/apr_level_decode.sv
module apr_level_decode #(
    parameter int EFF_BITS  = 6,
    parameter int NUM_WORDS = 2
) (
    input  logic [7:0]                  prio,
    output logic [NUM_WORDS-1:0][31:0]  level_mask
);
    localparam int SH = 8 - EFF_BITS;

    logic [EFF_BITS-1:0] idx;
    logic [4:0]          bit_in_word;

    assign idx         = EFF_BITS'(prio >> SH);
    assign bit_in_word = idx[4:0];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign level_mask[w] = ((32'(idx) >> 5) == 32'(w)) ? (32'd1 << bit_in_word) : 32'd0;
    end
endmodule

// File: rtl/apr_bank_next.sv
module apr_bank_next #(
    parameter int W = 64
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] set_mask,
    input  logic         set_en,
    input  logic         clr_en,
    output logic [W-1:0] nxt
);
    logic [W-1:0] after_set;

    always_comb begin
        after_set = cur | (set_en ? set_mask : '0);
        // x & (x-1) removes the lowest set bit; an empty bank stays empty
        nxt = clr_en ? (after_set & (after_set - W'(1))) : after_set;
    end
endmodule

// File: rtl/apr_lowbit.sv
module apr_lowbit #(
    parameter int W = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/apr_tracker.sv
module apr_tracker #(
    parameter int PRIO_BITS = 6,
    parameter bit VIRTUAL   = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act_valid,
    input  logic       act_group,
    input  logic [7:0] act_prio,
    input  logic       drop_valid,
    input  logic       drop_group,
    output logic [7:0] run_prio,
    output logic       run_group
);
    import apr_pkg::*;

    localparam int EFF_BITS  = eff_bits(PRIO_BITS, VIRTUAL);
    localparam int SH        = 8 - EFF_BITS;
    localparam int LEVELS    = 1 << EFF_BITS;
    localparam int NUM_WORDS = LEVELS / 32;
    localparam int W         = NUM_WORDS * 32;

    typedef logic [NUM_WORDS-1:0][31:0] bank_t;

    typedef struct packed {
        bank_t [1:0] grp;
    } state_t;

    state_t st_d, st_q;

    bank_t                     act_mask;
    logic  [1:0][W-1:0]        bank_nxt;
    logic  [1:0]               lo_found;
    logic  [1:0][EFF_BITS-1:0] lo_idx;

    apr_level_decode #(
        .EFF_BITS  (EFF_BITS),
        .NUM_WORDS (NUM_WORDS)
    ) u_decode (
        .prio       (act_prio),
        .level_mask (act_mask)
    );

    for (genvar g = 0; g < 2; g++) begin : g_grp
        apr_bank_next #(.W(W)) u_next (
            .cur      (st_q.grp[g]),
            .set_mask (act_mask),
            .set_en   (act_valid && (act_group == 1'(g))),
            .clr_en   (drop_valid && (drop_group == 1'(g))),
            .nxt      (bank_nxt[g])
        );

        apr_lowbit #(.W(W)) u_low (
            .vec   (st_q.grp[g]),
            .found (lo_found[g]),
            .idx   (lo_idx[g])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int g = 0; g < 2; g++) begin
            st_d.grp[g] = bank_t'(bank_nxt[g]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Running priority: lowest level across groups, group 0 wins ties
    always_comb begin
        if (lo_found[0] && (!lo_found[1] || (lo_idx[0] <= lo_idx[1]))) begin
            run_prio  = 8'(lo_idx[0]) << SH;
            run_group = GRP_0;
        end else if (lo_found[1]) begin
            run_prio  = 8'(lo_idx[1]) << SH;
            run_group = GRP_1;
        end else begin
            run_prio  = 8'hFF;
            run_group = GRP_0;
        end
    end
endmodule

// File: rtl/apr_tracker_chk.sv
module apr_tracker_chk #(
    parameter int PRIO_BITS = 6,
    parameter bit VIRTUAL   = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       act_valid,
    input logic       act_group,
    input logic [7:0] act_prio,
    input logic       drop_valid,
    input logic [7:0] run_prio,
    input logic       run_group
);
    localparam int SH = 8 - apr_pkg::eff_bits(PRIO_BITS, VIRTUAL);
    localparam logic [7:0] LOW_MASK = 8'((9'd1 << SH) - 9'd1);

    logic [7:0] act_map;
    assign act_map = 8'((act_prio >> SH) << SH);

    // R1 / R2: first activate from idle is reported with the mapped priority
    a_r1_first_activate: assert property (@(posedge clk) disable iff (!rst_n)
        (run_prio == 8'hFF && act_valid && !drop_valid)
        |=> (run_prio == $past(act_map) && run_group == $past(act_group)));

    // R5: idle reports group 0
    a_r5_idle_group: assert property (@(posedge clk) disable iff (!rst_n)
        (run_prio == 8'hFF) |-> (run_group == 1'b0));

    // R7: a drop with nothing active leaves the block idle
    a_r7_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (run_prio == 8'hFF && drop_valid && !act_valid) |=> (run_prio == 8'hFF));

    // R9: no strobe, no change
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_valid && !drop_valid) |=> ($stable(run_prio) && $stable(run_group)));

    // R4: an activate can only make the running priority more urgent
    a_r4_act_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && !drop_valid) |=> (run_prio <= $past(run_prio)));

    // R6: a drop can only make the running priority less urgent
    a_r6_drop_no_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_valid && !act_valid) |=> (run_prio >= $past(run_prio)));

    // R1: reported priorities are aligned to a level
    a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (run_prio != 8'hFF) |-> ((run_prio & LOW_MASK) == 8'h00));
endmodule

bind apr_tracker apr_tracker_chk #(
    .PRIO_BITS (PRIO_BITS),
    .VIRTUAL   (VIRTUAL)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_valid  (act_valid),
    .act_group  (act_group),
    .act_prio   (act_prio),
    .drop_valid (drop_valid),
    .run_prio   (run_prio),
    .run_group  (run_group)
);

// File: tb/test_apr_tracker.sv
module test_apr_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       act_valid = 1'b0;
    logic       act_group = 1'b0;
    logic [7:0] act_prio = 8'h00;
    logic       drop_valid = 1'b0;
    logic       drop_group = 1'b0;
    logic [7:0] run_prio, v_run_prio;
    logic       run_group, v_run_group;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // model: [config][group][level]; config 0 = 64 levels, config 1 = reduced 32 levels
    bit mdl [2][2][64];

    always #5 clk = ~clk;

    apr_tracker #(.PRIO_BITS(6), .VIRTUAL(1'b0)) i_apr_tracker (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_group(act_group),
        .act_prio(act_prio), .drop_valid(drop_valid), .drop_group(drop_group),
        .run_prio(run_prio), .run_group(run_group));

    apr_tracker #(.PRIO_BITS(6), .VIRTUAL(1'b1)) i_apr_tracker_virt (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_group(act_group),
        .act_prio(act_prio), .drop_valid(drop_valid), .drop_group(drop_group),
        .run_prio(v_run_prio), .run_group(v_run_group));

    function automatic logic [8:0] expect_run(input int c);
        int sh   = (c == 0) ? 2 : 3;
        int lvls = (c == 0) ? 64 : 32;
        for (int i = 0; i < lvls; i++) begin
            if (mdl[c][0][i]) return {1'b0, 8'(i << sh)};
            if (mdl[c][1][i]) return {1'b1, 8'(i << sh)};
        end
        return {1'b0, 8'hFF};
    endfunction

    task automatic check(input string req, input logic [7:0] gp, input logic gg,
                         input logic [8:0] ex);
        checks++;
        if (gp !== ex[7:0] || gg !== ex[8]) begin
            errors++;
            $display("FAIL %s: got prio=%02h group=%0d, expected prio=%02h group=%0d",
                     req, gp, gg, ex[7:0], ex[8]);
        end
    endtask

    task automatic step(input bit av, input bit ag, input logic [7:0] ap,
                        input bit dv, input bit dg, input string req);
        @(negedge clk);
        act_valid = av; act_group = ag; act_prio = ap;
        drop_valid = dv; drop_group = dg;
        for (int c = 0; c < 2; c++) begin
            int sh   = (c == 0) ? 2 : 3;
            int lvls = (c == 0) ? 64 : 32;
            if (av) mdl[c][ag][int'(ap) >> sh] = 1'b1;
            if (dv) begin
                bit done = 1'b0;
                for (int i = 0; i < lvls; i++) begin
                    if (!done && mdl[c][dg][i]) begin
                        mdl[c][dg][i] = 1'b0;
                        done = 1'b1;
                    end
                end
            end
        end
        @(negedge clk);
        act_valid = 1'b0; drop_valid = 1'b0;
        check(req, run_prio, run_group, expect_run(0));
        check((req == "R1") ? "R2" : req, v_run_prio, v_run_group, expect_run(1));
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_2468;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10, R5: empty after reset
        check("R10", run_prio, run_group, {1'b0, 8'hFF});
        check("R5", v_run_prio, v_run_group, {1'b0, 8'hFF});

        // R1 / R2 sweep: every priority in each group, then drop it (R6)
        for (int p = 0; p < 256; p++) begin
            for (int g = 0; g < 2; g++) begin
                step(1'b1, 1'(g), 8'(p), 1'b0, 1'b0, "R1");
                step(1'b0, 1'b0, 8'h00, 1'b1, 1'(g), "R6");
            end
        end

        // R7: drop with nothing active
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R7");
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R7");
        step(1'b1, 1'b1, 8'h40, 1'b0, 1'b0, "R7");
        // R4 tie: same level in both groups, group 0 wins
        step(1'b1, 1'b0, 8'h41, 1'b0, 1'b0, "R4");
        // R3: dropping group 0 leaves group 1 level in place
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R3");
        // R7: drop on empty group 0 while group 1 busy
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R7");
        // R4 ordering across groups
        step(1'b1, 1'b1, 8'h10, 1'b0, 1'b0, "R4");
        step(1'b1, 1'b0, 8'h80, 1'b0, 1'b0, "R4");
        step(1'b1, 1'b1, 8'h20, 1'b0, 1'b0, "R4");
        // R6: group 1 drop releases 0x10 only
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R6");
        // R3: group 0 drop does not touch group 1
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R3");
        // R8: same-cycle activate and drop in one group
        step(1'b1, 1'b0, 8'h08, 1'b1, 1'b0, "R8");
        step(1'b1, 1'b1, 8'h04, 1'b1, 1'b1, "R8");
        step(1'b1, 1'b0, 8'hF0, 1'b1, 1'b1, "R8");
        // R9: idle cycles hold
        repeat (4) step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R9");
        // upper storage word only (levels 32..63)
        step(1'b1, 1'b1, 8'hC4, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b1, 8'h84, 1'b0, 1'b0, "R1");

        // pseudo-random run against the model
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[0], lfsr[1], lfsr[15:8], lfsr[2] & lfsr[3] | lfsr[4], lfsr[5], "R4");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule